// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address, already rewritten by any context-switch logic upstream, into a physical address. It does this by fetching descriptors from a two-level translation table held in memory. A request carries the address together with a table base register. The walker first reads one first-level word. Depending on that word's type, it either finishes at once or makes a second read from a coarse or fine second-level table. It then returns the physical address, the mapping size, the domain and the permission field that applies to the access, or it returns a fault tagged with the level that failed.

All three data paths use valid/ready handshakes. A request is accepted only while the walker is idle (`req_ready` high). Descriptor reads go out with `mem_rd_valid` and an address. The address is held unchanged until `mem_rd_ready` accepts it. The walker then raises `mem_rsp_ready` and waits for one returned word, so at most one read is ever in flight. The result is held, unchanged, on the response port until `resp_ready` takes it. Back-pressure on either side simply stretches the walk, and no new request is taken until the result has left.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a walk goes to {ttb[31:14], va[31:20], 2'b00}. Bits [13:0] of the base register have no effect.
- R2: A first-level word with type bits [1:0]=10 maps a section and ends the walk after one read. The walker returns pa={d[31:20], va[19:0]}, size code 0, domain d[8:5] and permission d[11:10].
- R3: Type 01 (coarse) causes a second read at {d[31:10], va[19:12], 2'b00}.
- R4: Type 11 (fine) causes a second read at {d[31:12], va[19:10], 2'b00}.
- R5: A second-level word with type 01 is a large page: pa={e[31:16], va[15:0]}, size code 1. The permission is the quarter field e[5+2q:4+2q], with q=va[15:14].
- R6: A second-level word with type 10 is a small page: pa={e[31:12], va[11:0]}, size code 2. The permission is e[5+2q:4+2q], with q=va[11:10].
- R7: A second-level word with type 11 found in a fine table is a tiny page: pa={e[31:10], va[9:0]}, size code 3, permission e[5:4].
- R8: A first-level type 00 reports fault=1 and fault level 0. The walk ends after one read, and pa, size, domain and permission are all 0.
- R9: A second-level type 00, or type 11 found in a coarse table, reports fault=1 and fault level 1. In that case pa, size and permission are 0 and the domain is still reported.
- R10: For every page mapping, the domain comes from bits [8:5] of the first-level word.
- R11: Only one read is outstanding at a time. The read address stays stable while the read waits for ready, and `mem_rsp_ready` is high only while a read is pending.
- R12: The response stays stable while it waits for `resp_ready`, and `req_ready` stays low from request acceptance until the response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_ttb | input | 32 | Table base register, bits [31:14] used |
| mem_rd_valid | output | 1 | Descriptor read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Descriptor word |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_pa | output | 32 | Physical address |
| resp_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| resp_domain | output | 4 | Domain number |
| resp_ap | output | 2 | Permission field for the access |
| resp_fault | output | 1 | Translation fault |
| resp_fault_lvl | output | 1 | Faulting level: 0 first, 1 second |

## Verification
Two things can meet in the same cycle. A finished result can be stalled by a low `resp_ready` at the very moment a new request is already asserted on `req_valid`. The bench provokes this by raising the next request, with a different address, throughout the response stall. It then judges that `req_ready` stays low, that the held result does not change, and that the request is taken only after the handshake. Read-side stalls of varying length are also applied while the address is being held, and the bench confirms that no second read appears before the data returns.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int AW     = 32;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 2;
  localparam int N_QTR  = 4;
  localparam int QSEL_W = $clog2(N_QTR);

  typedef enum logic [1:0] {
    MAP_SECTION = 2'd0,
    MAP_LARGE   = 2'd1,
    MAP_SMALL   = 2'd2,
    MAP_TINY    = 2'd3
  } map_size_e;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1_RD, S_L1_WT, S_L2_RD, S_L2_WT, S_DONE
  } walk_state_e;

  typedef struct packed {
    logic [AW-1:0]    pa;
    map_size_e        size;
    logic [DOM_W-1:0] domain;
    logic [AP_W-1:0]  ap;
    logic             fault;
    logic             fault_lvl;
  } walk_result_t;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output l1_kind_e      kind,
  output logic [AW-1:0] l2_addr,
  output walk_result_t  sect_res
);
  logic unused_l1;
  assign unused_l1 = ^{desc[9], desc[4:2], va[31:20]};

  always_comb begin
    kind = l1_kind_e'(desc[1:0]);
    if (kind == L1_FINE) l2_addr = {desc[31:12], va[19:10], 2'b00};
    else                 l2_addr = {desc[31:10], va[19:12], 2'b00};
    sect_res        = '0;
    sect_res.domain = desc[8:5];
    if (kind == L1_SECTION) begin
      sect_res.pa   = {desc[31:20], va[19:0]};
      sect_res.size = MAP_SECTION;
      sect_res.ap   = desc[11:10];
    end else if (kind == L1_FAULT) begin
      sect_res.domain    = '0;
      sect_res.fault     = 1'b1;
      sect_res.fault_lvl = 1'b0;
    end
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [AW-1:0]    desc,
  input  logic [AW-1:0]    va,
  input  logic             fine_tbl,
  input  logic [DOM_W-1:0] domain,
  output walk_result_t     res
);
  logic [AP_W-1:0] ap_q [N_QTR];
  logic unused_l2;
  assign unused_l2 = ^{desc[3:2], va[31:16]};

  for (genvar g = 0; g < N_QTR; g++) begin : g_ap
    assign ap_q[g] = desc[4 + AP_W*g +: AP_W];
  end

  always_comb begin
    res        = '0;
    res.domain = domain;
    unique case (desc[1:0])
      2'b01: begin
        res.pa   = {desc[31:16], va[15:0]};
        res.size = MAP_LARGE;
        res.ap   = ap_q[va[15:14]];
      end
      2'b10: begin
        res.pa   = {desc[31:12], va[11:0]};
        res.size = MAP_SMALL;
        res.ap   = ap_q[va[11:10]];
      end
      2'b11: begin
        if (fine_tbl) begin
          res.pa   = {desc[31:10], va[9:0]};
          res.size = MAP_TINY;
          res.ap   = ap_q[0];
        end else begin
          res.fault     = 1'b1;
          res.fault_lvl = 1'b1;
        end
      end
      default: begin
        res.fault     = 1'b1;
        res.fault_lvl = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_va,
  input  logic [AW-1:0]    req_ttb,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [AW-1:0]    mem_rsp_data,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [AW-1:0]    resp_pa,
  output logic [1:0]       resp_size,
  output logic [DOM_W-1:0] resp_domain,
  output logic [AP_W-1:0]  resp_ap,
  output logic             resp_fault,
  output logic             resp_fault_lvl
);
  walk_state_e      state;
  logic [AW-1:0]    va_q;
  logic [AW-1:0]    addr_q;
  logic             fine_q;
  logic [DOM_W-1:0] dom_q;
  walk_result_t     res_q;

  l1_kind_e      l1_kind;
  logic [AW-1:0] l2_addr;
  walk_result_t  l1_res;
  walk_result_t  l2_res;

  logic unused_ttb;
  assign unused_ttb = ^req_ttb[13:0];

  ptw_l1_decode u_l1 (
    .desc     (mem_rsp_data),
    .va       (va_q),
    .kind     (l1_kind),
    .l2_addr  (l2_addr),
    .sect_res (l1_res)
  );

  ptw_l2_decode u_l2 (
    .desc     (mem_rsp_data),
    .va       (va_q),
    .fine_tbl (fine_q),
    .domain   (dom_q),
    .res      (l2_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      addr_q <= '0;
      fine_q <= 1'b0;
      dom_q  <= '0;
      res_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          addr_q <= {req_ttb[31:14], req_va[31:20], 2'b00};
          state  <= S_L1_RD;
        end
        S_L1_RD: if (mem_rd_ready) state <= S_L1_WT;
        S_L1_WT: if (mem_rsp_valid) begin
          if (l1_kind == L1_SECTION || l1_kind == L1_FAULT) begin
            res_q <= l1_res;
            state <= S_DONE;
          end else begin
            addr_q <= l2_addr;
            fine_q <= (l1_kind == L1_FINE);
            dom_q  <= l1_res.domain;
            state  <= S_L2_RD;
          end
        end
        S_L2_RD: if (mem_rd_ready) state <= S_L2_WT;
        S_L2_WT: if (mem_rsp_valid) begin
          res_q <= l2_res;
          state <= S_DONE;
        end
        S_DONE: if (resp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == S_IDLE);
  assign mem_rd_valid   = (state == S_L1_RD) || (state == S_L2_RD);
  assign mem_rd_addr    = addr_q;
  assign mem_rsp_ready  = (state == S_L1_WT) || (state == S_L2_WT);
  assign resp_valid     = (state == S_DONE);
  assign resp_pa        = res_q.pa;
  assign resp_size      = res_q.size;
  assign resp_domain    = res_q.domain;
  assign resp_ap        = res_q.ap;
  assign resp_fault     = res_q.fault;
  assign resp_fault_lvl = res_q.fault_lvl;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_va,
  input logic [AW-1:0]    req_ttb,
  input logic             mem_rd_valid,
  input logic             mem_rd_ready,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rsp_valid,
  input logic             mem_rsp_ready,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [AW-1:0]    resp_pa,
  input logic [1:0]       resp_size,
  input logic [DOM_W-1:0] resp_domain,
  input logic [AP_W-1:0]  resp_ap,
  input logic             resp_fault,
  input logic             resp_fault_lvl
);
  logic          rd_fire, rsp_fire, req_fire, out_fire;
  logic [1:0]    outst;
  logic [1:0]    rd_n;
  logic          busy;
  logic [AW-1:0] va_c, ttb_c;

  assign rd_fire  = mem_rd_valid && mem_rd_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;
  assign req_fire = req_valid && req_ready;
  assign out_fire = resp_valid && resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst <= '0;
      rd_n  <= '0;
      busy  <= 1'b0;
      va_c  <= '0;
      ttb_c <= '0;
    end else begin
      outst <= outst + 2'(rd_fire) - 2'(rsp_fire);
      if (req_fire) begin
        rd_n  <= '0;
        busy  <= 1'b1;
        va_c  <= req_va;
        ttb_c <= req_ttb;
      end else begin
        if (rd_fire) rd_n <= rd_n + 2'd1;
        if (out_fire) busy <= 1'b0;
      end
    end
  end

  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && rd_n == 2'd0 |-> mem_rd_addr == {ttb_c[31:14], va_c[31:20], 2'b00}); // R1
  AST_SECTION_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault && resp_size == 2'd0 |-> rd_n == 2'd1); // R2
  AST_PAGE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault_lvl || resp_size != 2'd0) |-> rd_n == 2'd2); // R3
  AST_L1_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault && !resp_fault_lvl |-> rd_n == 2'd1 && resp_domain == '0); // R8
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> resp_pa == '0 && resp_ap == '0); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> outst == 2'd0); // R11
  AST_RSP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> outst == 2'd1); // R11
  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R11
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid &&
      $stable({resp_pa, resp_size, resp_domain, resp_ap, resp_fault, resp_fault_lvl})); // R12
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R12
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .req_ttb(req_ttb), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_pa(resp_pa),
  .resp_size(resp_size), .resp_domain(resp_domain), .resp_ap(resp_ap),
  .resp_fault(resp_fault), .resp_fault_lvl(resp_fault_lvl)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [31:0] req_ttb = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_pa;
  logic [1:0]  resp_size;
  logic [3:0]  resp_domain;
  logic [1:0]  resp_ap;
  logic        resp_fault;
  logic        resp_fault_lvl;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ptw_walker uut (.*);

  typedef struct packed {
    logic [31:0] va, ttb, d1, d2, pa;
    logic [1:0]  size;
    logic [3:0]  dom;
    logic [1:0]  ap;
    logic        flt, lvl;
    logic [3:0]  rd_lat, rsp_lat, resp_lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h12345678, 32'h00040000, 32'h87600CA2, 32'h0, 32'h87645678, 2'd0, 4'd5,  2'd3, 1'b0, 1'b0, 4'd0, 4'd0, 4'd0},
    '{32'h00159ABC, 32'h00040000, 32'h00080521, 32'hABCD0E41, 32'hABCD9ABC, 2'd1, 4'd9,  2'd2, 1'b0, 1'b0, 4'd2, 4'd1, 4'd3},
    '{32'h00273C10, 32'h00043FFF, 32'h00091063, 32'h05556402, 32'h05556C10, 2'd2, 4'd3,  2'd1, 1'b0, 1'b0, 4'd0, 4'd3, 4'd1},
    '{32'h003703FF, 32'h00040000, 32'h000A21E3, 32'h12345C23, 32'h12345FFF, 2'd3, 4'd15, 2'd2, 1'b0, 1'b0, 4'd1, 4'd0, 4'd2},
    '{32'hFFF00000, 32'hFFFFFFFF, 32'hFFFFFFFC, 32'h0, 32'h00000000, 2'd0, 4'd0,  2'd0, 1'b1, 1'b0, 4'd3, 4'd2, 4'd0},
    '{32'h00501000, 32'h00040000, 32'h000804C1, 32'h00000000, 32'h00000000, 2'd0, 4'd6,  2'd0, 1'b1, 1'b1, 4'd0, 4'd0, 4'd1},
    '{32'h00602000, 32'h00040000, 32'h00080441, 32'h12345C23, 32'h00000000, 2'd0, 4'd2,  2'd0, 1'b1, 1'b1, 4'd1, 4'd1, 4'd0},
    '{32'h00700123, 32'h00040000, 32'h00080401, 32'hFEDCB032, 32'hFEDCB123, 2'd2, 4'd0,  2'd3, 1'b0, 1'b0, 4'd0, 4'd2, 4'd0},
    '{32'h00814000, 32'h00040000, 32'h000B3023, 32'h77770091, 32'h77774000, 2'd1, 4'd1,  2'd2, 1'b0, 1'b0, 4'd2, 4'd0, 4'd4}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic serve_read(input string rq, input logic [31:0] exp_addr,
                            input logic [31:0] data, input int rd_lat, input int rsp_lat);
    while (!mem_rd_valid) @(negedge clk);
    chk(rq, mem_rd_addr, exp_addr);
    for (int i = 0; i < rd_lat; i++) begin
      @(negedge clk);
      chk("R11", {31'd0, mem_rd_valid}, 32'd1);
      chk("R11", mem_rd_addr, exp_addr);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk("R11", {30'd0, mem_rd_valid, mem_rsp_ready}, 32'd1);
    for (int i = 0; i < rsp_lat; i++) @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEADBEEF;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] held;
    bit two;
    two = (v.d1[1:0] == 2'b01) || (v.d1[1:0] == 2'b11);
    @(negedge clk);
    req_va = v.va; req_ttb = v.ttb; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    serve_read("R1", {v.ttb[31:14], v.va[31:20], 2'b00}, v.d1, v.rd_lat, v.rsp_lat);
    if (two) begin
      if (v.d1[1:0] == 2'b11)
        serve_read("R4", {v.d1[31:12], v.va[19:10], 2'b00}, v.d2, v.rd_lat, v.rsp_lat);
      else
        serve_read("R3", {v.d1[31:10], v.va[19:12], 2'b00}, v.d2, v.rd_lat, v.rsp_lat);
    end
    while (!resp_valid) @(negedge clk);
    chk(v.flt ? (v.lvl ? "R9" : "R8") : "R11", {31'd0, mem_rd_valid}, 32'd0);
    chk(v.flt ? (v.lvl ? "R9" : "R8") :
        (v.size == 2'd0 ? "R2" : v.size == 2'd1 ? "R5" : v.size == 2'd2 ? "R6" : "R7"),
        {resp_pa}, v.pa);
    chk(v.flt ? "R9" : "R5", {30'd0, resp_size}, {30'd0, v.size});
    chk("R10", {28'd0, resp_domain}, {28'd0, v.dom});
    chk(v.flt ? "R8" : "R6", {30'd0, resp_ap}, {30'd0, v.ap});
    chk(v.lvl ? "R9" : "R8", {30'd0, resp_fault, resp_fault_lvl}, {30'd0, v.flt, v.lvl});
    held = resp_pa;
    // competing request raised while the result is back-pressured
    if (v.resp_lat != 0) begin
      req_va = ~v.va; req_valid = 1'b1;
    end
    for (int i = 0; i < v.resp_lat; i++) begin
      @(negedge clk);
      chk("R12", {30'd0, resp_valid, req_ready}, 32'd2);
      chk("R12", resp_pa, held);
    end
    req_valid = 1'b0;
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk("R12", {30'd0, resp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R12", {28'd0, req_ready, mem_rd_valid, mem_rsp_ready, resp_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {28'd0, req_ready, mem_rd_valid, mem_rsp_ready, resp_valid}, 32'h8);
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);
    // directed: spurious memory data while idle must not start or finish anything
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h87600CA2;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R11", {28'd0, req_ready, mem_rd_valid, mem_rsp_ready, resp_valid}, 32'h8);
    // directed: back-to-back walks after a stalled one, low base bits ignored
    run_vec('{32'hABC00FFF, 32'h00043ABC, 32'h11100002, 32'h0, 32'h11100FFF, 2'd0, 4'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'd0, 4'd5});
    run_vec(VECS[1]);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule